// File: doc/BRIEF.md
# Indirect Flash Read Engine

This block runs one programmed bulk read from a serial flash device into an on-chip word buffer. A host drains that buffer. Before it starts a read, software sets up the following:

- the opcode
- a lane-width code for each of the three phases
- an address length and a start address
- an optional mode byte
- a dummy clock count
- a byte count

Writing the start bit then launches the transfer. The engine sends the opcode, then the address with the most significant byte first, then the mode byte if it is enabled, then the dummy clocks. After that it collects data bytes.

The engine does not drive pins. It hands one item at a time to a byte-level serial shifter over a request/acknowledge handshake. An item is a byte to send, a byte to receive, or a run of dummy clocks. The engine holds chip select for as long as the transfer runs. Received bytes are packed into 32-bit words, and the words go into a first-in first-out buffer. The buffer reports its fill level in words, and host pops remove the head word.

A status pair reports progress. The busy flag is set while a transfer runs. The done flag is set once the final word has been stored and chip select has been dropped. Software clears done by writing a one to it. A cancel request stops a running transfer at once, and done stays low.

Top module: `flash_bulk_reader`

## Requirements
- R1: After reset, busy, done, chip select and the shifter request are low, and the buffer level is 0.
- R2: A control write with bit 0 set while idle starts a transfer, and busy reads 1 from the following cycle. A start write while busy is ignored, and the running sequence is not restarted.
- R3: The first item is a send item (kind 0) carrying the opcode on the instruction lane code. It is followed by N = (address length field bits [1:0]) + 1 address bytes, sent most significant byte first on the address lane code. Lane codes are 0 single, 1 dual and 2 quad.
- R4: When mode enable is set, exactly one send item carrying the mode value follows the address, on the address lane code. When mode enable is clear, no mode item is sent.
- R5: When the dummy count is non-zero, a single dummy item (kind 2) carries that count in its byte and uses the address lane code. When the count is zero, the dummy item is skipped.
- R6: Exactly byte-count receive items (kind 1) follow on the data lane code. Bytes are packed little-endian, so the first byte lands in bits [7:0] of a word.
- R7: When the byte count is not a multiple of 4, the final word is stored with its unused upper bytes set to zero.
- R8: The buffer level is a 16-bit count of stored words. A pop takes off the head word, and a pop while the buffer is empty changes nothing.
- R9: While the buffer is full, no receive item is requested. Requests resume after the host pops.
- R10: Done rises only after the last word is stored and chip select is low.
- R11: A control write with bit 5 set clears done. A write with bit 5 clear leaves done unchanged.
- R12: A control write with bit 1 set during a transfer returns the engine to idle on the next cycle. Busy and chip select drop, and done is not set.
- R13: With a byte count of 0, the header is still sent, no receive items are issued, and done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 0 start, bit 1 cancel, bit 5 clear done |
| cfg_opcode | input | 8 | Read opcode |
| cfg_instr_lanes | input | 2 | Lane code for the opcode |
| cfg_addr_lanes | input | 2 | Lane code for the address, mode and dummy items |
| cfg_data_lanes | input | 2 | Lane code for the data bytes |
| cfg_mode_en | input | 1 | Send the mode byte after the address |
| cfg_mode_val | input | 8 | Mode byte value |
| cfg_dummy | input | 5 | Dummy clock count |
| cfg_addr_len_m1 | input | 4 | Address bytes minus one |
| cfg_start_addr | input | 32 | Flash start address |
| cfg_byte_count | input | 32 | Number of bytes to read |
| stat_busy | output | 1 | Transfer in progress |
| stat_done | output | 1 | Transfer completed (sticky) |
| sh_req | output | 1 | Item request to the shifter |
| sh_kind | output | 2 | Item kind: 0 send, 1 receive, 2 dummy |
| sh_tx_byte | output | 8 | Byte to send, or dummy count |
| sh_lanes | output | 2 | Lane code for this item |
| sh_cs | output | 1 | Chip select active |
| sh_ack | input | 1 | Shifter has finished the item |
| sh_rx_byte | input | 8 | Received byte, valid with the acknowledge |
| buf_pop | input | 1 | Remove the head word |
| buf_rdata | output | 32 | Head word of the buffer |
| buf_level | output | 16 | Words held in the buffer |

## Verification
The hardest state to reach is a buffer that fills up while a read is still running. It needs a byte count larger than the buffer can hold and a host that stops popping. The bench starts a 40-byte read, does not pop, and waits until the level reaches the buffer depth. It then checks that receive requests stop, sends a start write into the busy engine, and drains the buffer word by word while the shifter model resumes. Cancel is exercised with requests still outstanding, and the acknowledge that lands in the same cycle must be dropped.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA, ST_RELEASE
   } fbr_state_e;

   localparam logic [1:0] SK_TX    = 2'd0;
   localparam logic [1:0] SK_RX    = 2'd1;
   localparam logic [1:0] SK_DUMMY = 2'd2;

   localparam int CTRL_START  = 0;
   localparam int CTRL_CANCEL = 1;
   localparam int CTRL_DONE   = 5;
endpackage

// File: rtl/fbr_pack.sv
module fbr_pack #(
   parameter int WORD_BYTES = 4,
   localparam int WORD_W = WORD_BYTES * 8,
   localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              byte_vld,
   input  logic [7:0]        byte_in,
   input  logic              byte_last,
   output logic              word_vld,
   output logic [WORD_W-1:0] word_out
);
   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("fbr_pack: WORD_BYTES must be a power of two");
   end

   if (WORD_BYTES == 1) begin : g_pass
      assign word_vld = byte_vld;
      assign word_out = byte_in;
   end else begin : g_acc
      logic [LANE_W-1:0] lane;
      logic [WORD_W-1:0] acc;
      logic [WORD_W-1:0] merged;

      always_comb begin
         merged = acc;
         merged[lane*8 +: 8] = byte_in;
      end

      assign word_out = merged;
      assign word_vld = byte_vld && ((lane == LANE_W'(WORD_BYTES - 1)) || byte_last);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane <= '0;
            acc  <= '0;
         end else if (clear) begin
            lane <= '0;
            acc  <= '0;
         end else if (byte_vld) begin
            if (word_vld) begin
               lane <= '0;
               acc  <= '0;
            end else begin
               lane <= lane + 1'b1;
               acc  <= merged;
            end
         end
      end

      // R7: a short final word never carries bytes above the last one written
      p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (word_vld && byte_last && lane == '0) |-> (word_out[WORD_W-1:8] == '0));
   end
endmodule

// File: rtl/fbr_wbuf.sv
module fbr_wbuf #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 32,
   parameter int LVL_W = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [LVL_W-1:0] level
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fbr_wbuf: DEPTH must be a power of two of at least 2");
   end
   if (DEPTH >= (1 << LVL_W)) begin : g_bad_lvl
      $error("fbr_wbuf: LVL_W too narrow for DEPTH");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             pop_ok;

   assign pop_ok = pop && (level != '0);
   assign rdata  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push)   wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (level < LVL_W'(DEPTH)));
   p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));
   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && level == '0 && !push) |=> (level == '0));
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
   import fbr_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 32,
   parameter int DUMMY_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic [7:0]         ctrl_wdata,
   input  logic [7:0]         cfg_opcode,
   input  logic [1:0]         cfg_instr_lanes,
   input  logic [1:0]         cfg_addr_lanes,
   input  logic [1:0]         cfg_data_lanes,
   input  logic               cfg_mode_en,
   input  logic [7:0]         cfg_mode_val,
   input  logic [DUMMY_W-1:0] cfg_dummy,
   input  logic [3:0]         cfg_addr_len_m1,
   input  logic [ADDR_W-1:0]  cfg_start_addr,
   input  logic [CNT_W-1:0]   cfg_byte_count,
   input  logic               buf_room,
   input  logic               sh_ack,
   output logic               sh_req,
   output logic [1:0]         sh_kind,
   output logic [7:0]         sh_tx_byte,
   output logic [1:0]         sh_lanes,
   output logic               sh_cs,
   output logic               busy,
   output logic               done,
   output logic               data_vld,
   output logic               data_last,
   output logic               pack_clear
);
   if (DUMMY_W > 8) begin : g_bad_dummy
      $error("fbr_seq: dummy count must fit the item byte");
   end

   fbr_state_e       state, after_addr, after_mode, after_dummy;
   logic [ADDR_W-1:0] addr_r;
   logic [CNT_W-1:0]  remain;
   logic [1:0]        idx, alen_m1;
   logic              start_go, cancel_go, clear_done, step;

   assign alen_m1    = cfg_addr_len_m1[1:0];
   assign start_go   = ctrl_wr && ctrl_wdata[CTRL_START] && (state == ST_IDLE);
   assign cancel_go  = ctrl_wr && ctrl_wdata[CTRL_CANCEL] && (state != ST_IDLE);
   assign clear_done = ctrl_wr && ctrl_wdata[CTRL_DONE];
   assign step       = sh_req && sh_ack;

   assign after_dummy = (remain != '0) ? ST_DATA : ST_RELEASE;
   assign after_mode  = (cfg_dummy != '0) ? ST_DUMMY : after_dummy;
   assign after_addr  = cfg_mode_en ? ST_MODE : after_mode;

   always_comb begin
      sh_req     = 1'b0;
      sh_kind    = SK_TX;
      sh_tx_byte = 8'h00;
      sh_lanes   = cfg_addr_lanes;
      unique case (state)
         ST_OPC: begin
            sh_req     = 1'b1;
            sh_tx_byte = cfg_opcode;
            sh_lanes   = cfg_instr_lanes;
         end
         ST_ADDR: begin
            sh_req     = 1'b1;
            sh_tx_byte = 8'(addr_r >> {(alen_m1 - idx), 3'b000});
         end
         ST_MODE: begin
            sh_req     = 1'b1;
            sh_tx_byte = cfg_mode_val;
         end
         ST_DUMMY: begin
            sh_req     = 1'b1;
            sh_kind    = SK_DUMMY;
            sh_tx_byte = 8'(cfg_dummy);
         end
         ST_DATA: begin
            sh_req   = buf_room;
            sh_kind  = SK_RX;
            sh_lanes = cfg_data_lanes;
         end
         default: ;
      endcase
   end

   assign sh_cs      = (state != ST_IDLE) && (state != ST_RELEASE);
   assign busy       = (state != ST_IDLE);
   assign data_vld   = (state == ST_DATA) && step && !cancel_go;
   assign data_last  = (remain == CNT_W'(1));
   assign pack_clear = start_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_r <= '0;
         remain <= '0;
         idx    <= '0;
         done   <= 1'b0;
      end else begin
         if (state == ST_RELEASE && !cancel_go) done <= 1'b1;
         else if (clear_done)                   done <= 1'b0;

         if (cancel_go) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: if (start_go) begin
                  state  <= ST_OPC;
                  addr_r <= cfg_start_addr;
                  remain <= cfg_byte_count;
                  idx    <= '0;
               end
               ST_OPC: if (step) state <= ST_ADDR;
               ST_ADDR: if (step) begin
                  if (idx == alen_m1) state <= after_addr;
                  else                idx   <= idx + 1'b1;
               end
               ST_MODE:  if (step) state <= after_mode;
               ST_DUMMY: if (step) state <= after_dummy;
               ST_DATA: if (step) begin
                  remain <= remain - 1'b1;
                  if (data_last) state <= ST_RELEASE;
               end
               ST_RELEASE: state <= ST_IDLE;
               default:    state <= ST_IDLE;
            endcase
         end
      end
   end

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> busy);
   p_done_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!sh_cs && state == ST_IDLE));
   p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_done && state != ST_RELEASE) |=> !done);
   p_cancel_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_go |=> (!busy && !sh_cs));
   p_cancel_nodone_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_go && !done) |=> !done);
endmodule

// File: rtl/flash_bulk_reader.sv
module flash_bulk_reader
   import fbr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 32,
   parameter int DUMMY_W    = 5,
   parameter int BUF_DEPTH  = 8,
   parameter int LVL_W      = 16,
   parameter int WORD_BYTES = 4,
   localparam int WORD_W    = WORD_BYTES * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic [7:0]         ctrl_wdata,
   input  logic [7:0]         cfg_opcode,
   input  logic [1:0]         cfg_instr_lanes,
   input  logic [1:0]         cfg_addr_lanes,
   input  logic [1:0]         cfg_data_lanes,
   input  logic               cfg_mode_en,
   input  logic [7:0]         cfg_mode_val,
   input  logic [DUMMY_W-1:0] cfg_dummy,
   input  logic [3:0]         cfg_addr_len_m1,
   input  logic [ADDR_W-1:0]  cfg_start_addr,
   input  logic [CNT_W-1:0]   cfg_byte_count,
   output logic               stat_busy,
   output logic               stat_done,
   output logic               sh_req,
   output logic [1:0]         sh_kind,
   output logic [7:0]         sh_tx_byte,
   output logic [1:0]         sh_lanes,
   output logic               sh_cs,
   input  logic               sh_ack,
   input  logic [7:0]         sh_rx_byte,
   input  logic               buf_pop,
   output logic [WORD_W-1:0]  buf_rdata,
   output logic [LVL_W-1:0]   buf_level
);
   logic              buf_room, data_vld, data_last, pack_clear, word_vld;
   logic [WORD_W-1:0] word_out;

   assign buf_room = (buf_level < LVL_W'(BUF_DEPTH));

   fbr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUMMY_W(DUMMY_W)) u_seq (
      .clk, .rst_n, .ctrl_wr, .ctrl_wdata,
      .cfg_opcode, .cfg_instr_lanes, .cfg_addr_lanes, .cfg_data_lanes,
      .cfg_mode_en, .cfg_mode_val, .cfg_dummy, .cfg_addr_len_m1,
      .cfg_start_addr, .cfg_byte_count,
      .buf_room, .sh_ack,
      .sh_req, .sh_kind, .sh_tx_byte, .sh_lanes, .sh_cs,
      .busy(stat_busy), .done(stat_done),
      .data_vld, .data_last, .pack_clear
   );

   fbr_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
      .clk, .rst_n, .clear(pack_clear),
      .byte_vld(data_vld), .byte_in(sh_rx_byte), .byte_last(data_last),
      .word_vld, .word_out
   );

   fbr_wbuf #(.DEPTH(BUF_DEPTH), .WIDTH(WORD_W), .LVL_W(LVL_W)) u_wbuf (
      .clk, .rst_n, .push(word_vld), .wdata(word_out),
      .pop(buf_pop), .rdata(buf_rdata), .level(buf_level)
   );

   p_stall_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_level == LVL_W'(BUF_DEPTH) && sh_kind == SK_RX) |-> !sh_req);
   p_cs_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sh_req |-> sh_cs);
endmodule

// File: tb/flash_bulk_reader_tb.sv
module flash_bulk_reader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic [7:0]  cfg_opcode = '0;
   logic [1:0]  cfg_instr_lanes = '0, cfg_addr_lanes = '0, cfg_data_lanes = '0;
   logic        cfg_mode_en = 1'b0;
   logic [7:0]  cfg_mode_val = 8'hA5;
   logic [4:0]  cfg_dummy = '0;
   logic [3:0]  cfg_addr_len_m1 = 4'd2;
   logic [31:0] cfg_start_addr = '0, cfg_byte_count = '0;
   logic        stat_busy, stat_done, sh_req, sh_cs;
   logic [1:0]  sh_kind, sh_lanes;
   logic [7:0]  sh_tx_byte;
   logic        sh_ack = 1'b0;
   logic [7:0]  sh_rx_byte = '0;
   logic        buf_pop = 1'b0;
   logic [31:0] buf_rdata;
   logic [15:0] buf_level;

   always #2 clk = ~clk;

   flash_bulk_reader u_dut (.*);

   int n_chk = 0, n_fail = 0;
   int lg_n = 0, rx_n = 0;
   logic [1:0] lg_kind [256];
   logic [7:0] lg_byte [256];
   logic [1:0] lg_lane [256];
   logic       lg_cs   [256];

   function automatic logic [7:0] pat(int n);
      return 8'((n * 37 + 90) & 255);
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // shifter model: one-cycle acknowledge per requested item
   initial begin
      forever begin
         @(negedge clk);
         if (sh_ack) sh_ack = 1'b0;
         else if (sh_req && lg_n < 256) begin
            lg_kind[lg_n] = sh_kind;
            lg_lane[lg_n] = sh_lanes;
            lg_cs[lg_n]   = sh_cs;
            if (sh_kind == 2'd1) begin
               sh_rx_byte = pat(rx_n);
               lg_byte[lg_n] = sh_rx_byte;
               rx_n++;
            end else lg_byte[lg_n] = sh_tx_byte;
            lg_n++;
            sh_ack = 1'b1;
         end
      end
   end

   task automatic ctrl_write(logic [7:0] d);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_wdata = d;
      @(negedge clk);
      ctrl_wr = 1'b0; ctrl_wdata = '0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000 && !stat_done; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_word(int w, int cnt);
      logic [31:0] v = '0;
      for (int b = 0; b < 4; b++)
         if (4 * w + b < cnt) v[8*b +: 8] = pat(4 * w + b);
      return v;
   endfunction

   task automatic pop_check(int w, int cnt, string req);
      @(negedge clk);
      chk(buf_rdata == exp_word(w, cnt), req, buf_rdata, exp_word(w, cnt));
      buf_pop = 1'b1;
      @(negedge clk);
      buf_pop = 1'b0;
   endtask

   task automatic header_check(int am1, bit men, int dmy, int li, int la, int op,
                               logic [31:0] addr, output int k);
      k = 0;
      chk(lg_kind[0] == 2'd0 && lg_byte[0] == 8'(op) && lg_lane[0] == 2'(li),
          "R3 opcode", {lg_kind[0], lg_lane[0], lg_byte[0]}, {2'd0, 2'(li), 8'(op)});
      k = 1;
      for (int j = 0; j <= am1; j++) begin
         logic [7:0] e = 8'(addr >> (8 * (am1 - j)));
         chk(lg_kind[k] == 2'd0 && lg_byte[k] == e && lg_lane[k] == 2'(la),
             "R3 address byte", lg_byte[k], e);
         k++;
      end
      if (men) begin
         chk(lg_kind[k] == 2'd0 && lg_byte[k] == 8'hA5 && lg_lane[k] == 2'(la),
             "R4 mode byte", lg_byte[k], 8'hA5);
         k++;
      end
      if (dmy != 0) begin
         chk(lg_kind[k] == 2'd2 && lg_byte[k] == 8'(dmy) && lg_lane[k] == 2'(la),
             "R5 dummy item", {lg_kind[k], lg_byte[k]}, {2'd2, 8'(dmy)});
         k++;
      end
   endtask

   task automatic prep(int am1, bit men, int dmy, int cnt, int li, int la, int ld,
                       int op, logic [31:0] addr);
      cfg_addr_len_m1 = 4'(am1); cfg_mode_en = men; cfg_dummy = 5'(dmy);
      cfg_byte_count = cnt; cfg_instr_lanes = 2'(li); cfg_addr_lanes = 2'(la);
      cfg_data_lanes = 2'(ld); cfg_opcode = 8'(op); cfg_start_addr = addr;
      lg_n = 0; rx_n = 0;
   endtask

   task automatic run_xfer(int am1, bit men, int dmy, int cnt, int li, int la, int ld,
                           int op, logic [31:0] addr);
      int k, nw;
      prep(am1, men, dmy, cnt, li, la, ld, op, addr);
      ctrl_write(8'h01);
      chk(stat_busy == 1'b1, "R2 busy after start", stat_busy, 1);
      wait_done();
      nw = (cnt + 3) / 4;
      chk(stat_done && !sh_cs, "R10 done with cs released", {stat_done, sh_cs}, 2'b10);
      chk(buf_level == 16'(nw), "R8 level in words", buf_level, nw);
      header_check(am1, men, dmy, li, la, op, addr, k);
      chk(lg_n == k + cnt, "R6 item count", lg_n, k + cnt);
      for (int j = 0; j < cnt; j++)
         chk(lg_kind[k+j] == 2'd1 && lg_lane[k+j] == 2'(ld) && lg_cs[k+j],
             "R6 receive item", {lg_kind[k+j], lg_lane[k+j]}, {2'd1, 2'(ld)});
      for (int w = 0; w < nw; w++)
         pop_check(w, cnt, (cnt % 4 != 0 && w == nw - 1) ? "R7 zero-filled tail" : "R6 packed word");
      chk(buf_level == 16'd0, "R8 level after pops", buf_level, 0);
      ctrl_write(8'h00);
      chk(stat_done == 1'b1, "R11 done kept on bit5 clear", stat_done, 1);
      ctrl_write(8'h20);
      chk(stat_done == 1'b0, "R11 done cleared", stat_done, 0);
   endtask

   typedef struct packed {
      logic [1:0] am1; logic men; logic [4:0] dmy; logic [7:0] cnt;
      logic [1:0] li; logic [1:0] la; logic [1:0] ld;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{2'd2, 1'b0, 5'd0,  8'd8, 2'd0, 2'd0, 2'd0},
      '{2'd3, 1'b1, 5'd6,  8'd5, 2'd0, 2'd1, 2'd2},
      '{2'd2, 1'b1, 5'd0,  8'd3, 2'd0, 2'd0, 2'd1},
      '{2'd3, 1'b0, 5'd8,  8'd1, 2'd2, 2'd2, 2'd2},
      '{2'd2, 1'b0, 5'd31, 8'd0, 2'd0, 2'd0, 2'd0}   // R13 zero-length read
   };

   initial begin
      repeat (3) @(negedge clk);
      chk(!stat_busy && !stat_done && !sh_cs && !sh_req && buf_level == 0, "R1 reset state",
          {stat_busy, stat_done, sh_cs, sh_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!stat_busy && !stat_done && !sh_cs && !sh_req && buf_level == 0, "R1 idle after reset",
          {stat_busy, stat_done, sh_cs, sh_req}, 0);

      // R8: pop on an empty buffer
      buf_pop = 1'b1; @(negedge clk); buf_pop = 1'b0; @(negedge clk);
      chk(buf_level == 0, "R8 empty pop ignored", buf_level, 0);

      for (int v = 0; v < 5; v++)
         run_xfer(VEC[v].am1, VEC[v].men, VEC[v].dmy, VEC[v].cnt, VEC[v].li, VEC[v].la,
                  VEC[v].ld, 8'h0B + v, 32'h12A1B2C3 + 32'(v * 32'h01010101));

      // R9: fill the buffer with no pops, then drain while the read resumes
      begin
         int k, w;
         prep(2, 1'b0, 0, 40, 0, 0, 1, 8'h3B, 32'h00445566);
         ctrl_write(8'h01);
         for (int i = 0; i < 500 && buf_level != 16'd8; i++) @(negedge clk);
         repeat (5) @(negedge clk);
         chk(buf_level == 16'd8, "R9 buffer full", buf_level, 8);
         chk(sh_req == 1'b0 && stat_busy, "R9 request held off", sh_req, 0);
         chk(rx_n == 32, "R9 receive count at stall", rx_n, 32);
         ctrl_write(8'h01);   // R2: start while busy
         w = 0;
         for (int i = 0; i < 2000 && w < 10; i++) begin
            if (buf_level != 0) begin pop_check(w, 40, "R9 word after stall"); w++; end
            else @(negedge clk);
         end
         wait_done();
         chk(w == 10, "R9 words drained", w, 10);
         header_check(2, 1'b0, 0, 0, 0, 8'h3B, 32'h00445566, k);
         chk(lg_n == 44, "R2 start ignored while busy", lg_n, 44);
         ctrl_write(8'h20);
      end

      // R12: cancel mid-transfer
      prep(2, 1'b1, 4, 20, 0, 0, 0, 8'h6B, 32'h00010203);
      ctrl_write(8'h01);
      for (int i = 0; i < 500 && rx_n < 3; i++) @(negedge clk);
      ctrl_write(8'h02);
      chk(!stat_busy && !sh_cs, "R12 idle after cancel", {stat_busy, sh_cs}, 0);
      repeat (10) @(negedge clk);
      chk(!stat_done && !sh_req, "R12 no done after cancel", {stat_done, sh_req}, 0);
      for (int i = 0; i < 20 && buf_level != 0; i++) begin
         buf_pop = 1'b1; @(negedge clk);
      end
      buf_pop = 1'b0;
      @(negedge clk);
      // recovery after cancel: a clean transfer packs from byte zero
      run_xfer(3, 1'b0, 2, 6, 1, 1, 1, 8'hEB, 32'hCAFE0102);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule